// File: doc/BRIEF.md
# Bipolar Step Staircase Pattern Source

This block is a stimulus source for checking that a converter stays monotonic near zero. It emits signed two's-complement samples in a fixed round. The round starts with a stretch of zero-code periods. Next comes a stretch of periods that swing between +1 and −1 LSB, then a stretch at ±2 LSB, and so on, growing by one LSB per stage up to a top magnitude. When the top stage ends, the round starts again at the zero stage.

A period is a fixed number of samples. Its first half carries +k and its second half carries −k, where k is the current stage. Samples leave through a valid/ready handshake, and the pattern moves one sample forward only when both are high. A stage-index output lets a bench or a monitor follow the sequence. A one-cycle wrap pulse marks the point where a round has just been completed.

Top module: `monoStepGen`

## Requirements
- R1: While the synchronous reset is high, `sampleValid` and `wrapPulse` are 0 and `stageIdx` is 0. On the first clock edge after reset is released, `sampleValid` rises, with `sampleData` = 0 and `stageIdx` = 0.
- R2: In stage 0, which spans the first REPEATS periods of a round, every sample is 0.
- R3: In stage k ≥ 1, the first PERIOD_LEN/2 samples of each period equal +k.
- R4: In stage k ≥ 1, the last PERIOD_LEN/2 samples of each period equal −k, encoded as 2^SAMPLE_W − k (for the default width, 0x100000 − k).
- R5: `stageIdx` shows the current stage k. It increases by exactly one after REPEATS complete periods have been accepted.
- R6: After the last accepted sample of stage MAX_STEP, the next sample is the first sample of stage 0.
- R7: `wrapPulse` is high for exactly one cycle, in the cycle after the handshake that accepts the last sample of stage MAX_STEP. It is low at all other times.
- R8: While `sampleReady` is low, `sampleData` and `stageIdx` hold their values and the pattern does not move forward.
- R9: Asserting reset in the middle of a round returns the pattern to the first sample of stage 0.
- R10: Once `sampleValid` has risen, it stays high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleReady | input | 1 | Consumer accepts the current sample |
| sampleValid | output | 1 | Sample is available |
| sampleData | output | SAMPLE_W | Two's-complement sample |
| stageIdx | output | $clog2(MAX_STEP+1) | Current stage (0 = zero stage) |
| wrapPulse | output | 1 | One-cycle marker after a completed round |

## Verification
The pattern is first drained with ready held high for more than a full round. This shows that the stage lengths, the sign split in each period and the wrap-around point all match an independent index model. The same walk is then repeated with irregular ready patterns, including long stalls. Under stalls, any advance without a handshake breaks the match, and so does any change of output while stalled. A reset partway through a round separates a true restart from a counter that only partly clears.

// File: rtl/monoStepPkg.sv
package monoStepPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic fire;      // handshake completes this cycle
    logic negHalf;   // current sample lies in the second half of its period
    logic roundEnd;  // current sample is the last one of the round
  } ctrlStrobes_t;
endpackage

// File: rtl/monoStepCtrl.sv
module monoStepCtrl
  import monoStepPkg::*;
#(
  parameter int PERIOD_LEN = 4,
  parameter int REPEATS    = 10,
  parameter int MAX_STEP   = 10,
  localparam int SAMP_CW   = (PERIOD_LEN > 2) ? $clog2(PERIOD_LEN) : 1,
  localparam int PER_CW    = (REPEATS > 2) ? $clog2(REPEATS) : 1,
  localparam int STAGE_W   = $clog2(MAX_STEP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleReady,
  output logic               validOut,
  output logic [STAGE_W-1:0] stageOut,
  output ctrlStrobes_t       strobes
);
  localparam int HALF = PERIOD_LEN / 2;
  localparam logic [SAMP_CW-1:0] SAMP_LAST  = SAMP_CW'(PERIOD_LEN - 1);
  localparam logic [SAMP_CW-1:0] SAMP_HALF  = SAMP_CW'(HALF);
  localparam logic [PER_CW-1:0]  PER_LAST   = PER_CW'(REPEATS - 1);
  localparam logic [STAGE_W-1:0] STAGE_LAST = STAGE_W'(MAX_STEP);

  logic               validQ;
  logic [SAMP_CW-1:0] sampleCnt;
  logic [PER_CW-1:0]  periodCnt;
  logic [STAGE_W-1:0] stageCnt;

  logic fire, lastSample, lastPeriod, lastStage;

  always_comb begin
    fire       = validQ & sampleReady;
    lastSample = (sampleCnt == SAMP_LAST);
    lastPeriod = (periodCnt == PER_LAST);
    lastStage  = (stageCnt == STAGE_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ    <= 1'b0;
      sampleCnt <= '0;
      periodCnt <= '0;
      stageCnt  <= '0;
    end else begin
      validQ <= 1'b1;
      if (fire) begin
        sampleCnt <= lastSample ? '0 : sampleCnt + 1'b1;
        if (lastSample) begin
          periodCnt <= lastPeriod ? '0 : periodCnt + 1'b1;
          if (lastPeriod)
            stageCnt <= lastStage ? '0 : stageCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.fire     = fire;
    strobes.negHalf  = (sampleCnt >= SAMP_HALF);
    strobes.roundEnd = lastSample & lastPeriod & lastStage;
    validOut         = validQ;
    stageOut         = stageCnt;
  end
endmodule

// File: rtl/monoStepData.sv
module monoStepData
  import monoStepPkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int STAGE_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STAGE_W-1:0]  stageIn,
  input  ctrlStrobes_t        strobes,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                wrapOut
);
  logic [SAMPLE_W-1:0] magnitude;
  logic                wrapQ;

  always_comb begin
    magnitude = SAMPLE_W'(stageIn);
    dataOut   = strobes.negHalf ? (~magnitude + 1'b1) : magnitude;
    wrapOut   = wrapQ;
  end

  always_ff @(posedge clk) begin
    if (rst) wrapQ <= 1'b0;
    else     wrapQ <= strobes.fire & strobes.roundEnd;
  end
endmodule

// File: rtl/monoStepGen.sv
module monoStepGen
  import monoStepPkg::*;
#(
  parameter int SAMPLE_W   = 20,
  parameter int PERIOD_LEN = 4,
  parameter int REPEATS    = 10,
  parameter int MAX_STEP   = 10,
  localparam int STAGE_W   = $clog2(MAX_STEP + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sampleReady,
  output logic                sampleValid,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic [STAGE_W-1:0]  stageIdx,
  output logic                wrapPulse
);
  ctrlStrobes_t strobes;

  monoStepCtrl #(
    .PERIOD_LEN(PERIOD_LEN), .REPEATS(REPEATS), .MAX_STEP(MAX_STEP)
  ) uCtrl (
    .clk(clk), .rst(rst), .sampleReady(sampleReady),
    .validOut(sampleValid), .stageOut(stageIdx), .strobes(strobes)
  );

  monoStepData #(
    .SAMPLE_W(SAMPLE_W), .STAGE_W(STAGE_W)
  ) uData (
    .clk(clk), .rst(rst), .stageIn(stageIdx), .strobes(strobes),
    .dataOut(sampleData), .wrapOut(wrapPulse)
  );
endmodule

// File: rtl/monoStepChk.sv
module monoStepChk #(
  parameter int SAMPLE_W = 20,
  parameter int MAX_STEP = 10,
  parameter int STAGE_W  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                sampleReady,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] sampleData,
  input logic [STAGE_W-1:0]  stageIdx,
  input logic                wrapPulse
);
  localparam logic [STAGE_W-1:0] TOP = STAGE_W'(MAX_STEP);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !sampleReady) |=> ($stable(sampleData) && $stable(stageIdx)));

  assert_wrap_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (wrapPulse && !$past(rst)) |-> ($past(sampleValid && sampleReady) && $past(stageIdx) == TOP));

  assert_stage_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && stageIdx != $past(stageIdx) && $past(stageIdx) != TOP)
      |-> (stageIdx == $past(stageIdx) + 1'b1));

  assert_stage_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && stageIdx != $past(stageIdx) && $past(stageIdx) == TOP)
      |-> (stageIdx == '0));

  assert_zero_stage_R2: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && stageIdx == '0) |-> (sampleData == '0));

  assert_valid_keep_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sampleValid)) |-> sampleValid);
endmodule

bind monoStepGen monoStepChk #(
  .SAMPLE_W(SAMPLE_W), .MAX_STEP(MAX_STEP), .STAGE_W(STAGE_W)
) uChk (
  .clk(clk), .rst(rst), .sampleReady(sampleReady), .sampleValid(sampleValid),
  .sampleData(sampleData), .stageIdx(stageIdx), .wrapPulse(wrapPulse)
);

// File: tb/tb_monoStepGen.sv
`timescale 1ns/1ps
module tb_monoStepGen;
  localparam int SW = 20, PL = 4, RP = 10, MX = 10;
  localparam int STW = $clog2(MX + 1);
  localparam int ROUND = (MX + 1) * RP * PL;

  logic clk = 1'b0, rst = 1'b1, sampleReady = 1'b0;
  logic sampleValid, wrapPulse;
  logic [SW-1:0] sampleData;
  logic [STW-1:0] stageIdx;

  int checks = 0, fails = 0, nIdx = 0, cycles = 0;
  logic prevLast = 1'b0;

  always #5 clk = ~clk;

  monoStepGen #(.SAMPLE_W(SW), .PERIOD_LEN(PL), .REPEATS(RP), .MAX_STEP(MX)) dut (
    .clk(clk), .rst(rst), .sampleReady(sampleReady), .sampleValid(sampleValid),
    .sampleData(sampleData), .stageIdx(stageIdx), .wrapPulse(wrapPulse));

  function automatic int expStage(int n);
    return (n / (RP * PL)) % (MX + 1);
  endfunction

  function automatic logic [SW-1:0] expData(int n);
    int k = expStage(n);
    if ((n % PL) >= PL / 2) return SW'((1 << SW) - k);
    return SW'(k);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (index %0d)", req, act, exp, nIdx);
    end
  endtask

  // one cycle at the negedge: drive ready, check outputs, then advance
  task automatic stepCycle(input logic rdy);
    string dReq;
    sampleReady = rdy;
    #1;
    check("R7", wrapPulse, prevLast);
    check("R10", sampleValid, 1);
    if (expStage(nIdx) == 0) dReq = "R2";
    else if ((nIdx % PL) >= PL / 2) dReq = "R4";
    else dReq = "R3";
    check(dReq, sampleData, expData(nIdx));
    check((nIdx >= ROUND) ? "R6" : "R5", stageIdx, expStage(nIdx));
    if (rdy) begin
      prevLast = ((nIdx % ROUND) == ROUND - 1);
      nIdx++;
    end else prevLast = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset();
    rst = 1'b1; sampleReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", sampleValid, 0);
    check("R1", wrapPulse, 0);
    check("R1", stageIdx, 0);
    rst = 1'b0;
    nIdx = 0; prevLast = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", sampleValid, 1);
    check("R1", sampleData, 0);
  endtask

  task automatic testFullRound();
    for (int i = 0; i < ROUND + 60; i++) stepCycle(1'b1);
  endtask

  task automatic testStalls();
    logic [SW-1:0] held;
    for (int i = 0; i < 3 * ROUND; i++) stepCycle(((i % 7) != 3) && ((i % 5) != 1));
    held = sampleData;
    for (int i = 0; i < 12; i++) stepCycle(1'b0);
    check("R8", sampleData, held);
  endtask

  task automatic testMidReset();
    for (int i = 0; i < 173; i++) stepCycle(1'b1);
    applyReset();
    check("R9", stageIdx, 0);
    check("R9", sampleData, 0);
    for (int i = 0; i < 50; i++) stepCycle(1'b1);
  endtask

  initial begin
    @(negedge clk);
    applyReset();
    testFullRound();
    testStalls();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule